// File: doc/BRIEF.md
# Lane-Partitioned Adder with Padded Elements

This block adds two 32-bit vectors that are split into independent lanes. A 2-bit mode input picks the split at run time: one 32-bit lane, two 16-bit lanes or four 8-bit lanes. Inside each lane only a narrower element takes part in the sum. It is 11 bits wide in the one-lane and two-lane splits and 5 bits wide in the four-lane split. Each element starts at the lowest bit of its lane, so every split places its operands with plain wiring and needs no repacking.

The sum is purely combinational. A carry runs only between neighbouring bits of the same element. Every element wraps modulo its own width, and its carry out goes to a dedicated per-element carry output instead of into the next element. The mode is decoded into one of three fixed carry-link patterns, one per split. Bit positions that no split ever uses are fixed at design time: no adder cell is built for them and they drive zero.

Top module: `simd_pad_adder`

## Requirements
- R1: With mode 0 (one 32-bit lane), sum bits 10..0 equal (a[10:0] + b[10:0]) mod 2^11, and carry_o[0] is the carry out of that 11-bit addition.
- R2: With mode 1 (two 16-bit lanes), there are two independent 11-bit elements at bits 10..0 and 26..16, and carry_o[1:0] holds their carries (bit 0 belongs to the low element).
- R3: With mode 2 (four 8-bit lanes), there are four independent 5-bit elements at bits 4..0, 12..8, 20..16 and 28..24, and carry_o[3:0] holds their carries (bit i belongs to element i, counted from the low end).
- R4: Mode 3 produces the same sum and carry outputs as mode 0 for any operands.
- R5: No carry crosses an element end. An element that overflows wraps, and the next element's sum is unaffected.
- R6: In every mode, each sum bit inside a lane but outside that mode's element is zero. The element masks are 0x000007FF for mode 0 and mode 3, 0x07FF07FF for mode 1, and 0x1F1F1F1F for mode 2.
- R7: Sum bits 31..29 and 15..13 lie outside every element of every mode and are zero for all inputs.
- R8: carry_o bits that belong to no element are zero: bits 3..1 in modes 0 and 3, and bits 3..2 in mode 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mode_i | input | 2 | Lane split: 0 = 1x32, 1 = 2x16, 2 = 4x8, 3 = treated as 1x32 |
| a_i | input | 32 | First operand vector |
| b_i | input | 32 | Second operand vector |
| sum_o | output | 32 | Element-wise sum, with padding bits forced to zero |
| carry_o | output | 4 | Carry out of each element, zero where no element exists |

## Verification
The hardest case to reach from the ports is a carry that is generated at the top of one element while the bits just above it are live in some other mode. Random operands seldom saturate an element exactly, so a leak across an element end would go unnoticed. The bench therefore drives all-ones and max-plus-one operands in every mode, so that each element overflows on purpose. It then checks that the neighbouring element, the lane padding and the always-blank bits stay clean, and that the carry shows up only on that element's carry output.

// File: rtl/simd_pad_pkg.sv
package simd_pad_pkg;

  typedef enum logic [1:0] {
    MODE_X1  = 2'd0,
    MODE_X2  = 2'd1,
    MODE_X4  = 2'd2,
    MODE_RSV = 2'd3
  } mode_e;

  localparam int MAXW = 64;

  function automatic int lanes_of(mode_e m);
    case (m)
      MODE_X2: return 2;
      MODE_X4: return 4;
      default: return 1;
    endcase
  endfunction

  function automatic int elem_w(mode_e m, int eww, int ewn);
    return (m == MODE_X4) ? ewn : eww;
  endfunction

  // bits occupied by the elements of one mode
  function automatic logic [MAXW-1:0] elem_mask(mode_e m, int vw, int eww, int ewn);
    logic [MAXW-1:0] r;
    int n;
    int lw;
    int ew;
    r  = '0;
    n  = lanes_of(m);
    lw = vw / n;
    ew = elem_w(m, eww, ewn);
    for (int l = 0; l < n; l++) begin
      for (int k = 0; k < ew; k++) begin
        r[l*lw+k] = 1'b1;
      end
    end
    return r;
  endfunction

  // bit b set: carry from bit b-1 may enter bit b
  function automatic logic [MAXW-1:0] link_mask(mode_e m, int vw, int eww, int ewn);
    logic [MAXW-1:0] em;
    logic [MAXW-1:0] r;
    int lw;
    em = elem_mask(m, vw, eww, ewn);
    r  = '0;
    lw = vw / lanes_of(m);
    for (int b = 1; b < vw; b++) begin
      if (em[b] && em[b-1] && ((b % lw) != 0)) r[b] = 1'b1;
    end
    return r;
  endfunction

  // single bit at the top of element 'lane', empty when the lane is absent
  function automatic logic [MAXW-1:0] tap_mask(mode_e m, int lane, int vw, int eww, int ewn);
    logic [MAXW-1:0] r;
    int n;
    int lw;
    r  = '0;
    n  = lanes_of(m);
    lw = vw / n;
    if (lane < n) r[lane*lw + elem_w(m, eww, ewn) - 1] = 1'b1;
    return r;
  endfunction

  function automatic logic [MAXW-1:0] union_mask(int vw, int eww, int ewn);
    return elem_mask(MODE_X1, vw, eww, ewn) |
           elem_mask(MODE_X2, vw, eww, ewn) |
           elem_mask(MODE_X4, vw, eww, ewn);
  endfunction

endpackage

// File: rtl/simd_pad_mode_dec.sv
module simd_pad_mode_dec
  import simd_pad_pkg::*;
#(
  parameter int VW        = 32,
  parameter int EW_WIDE   = 11,
  parameter int EW_NARROW = 5
) (
  input  logic [1:0]    mode_i,
  output logic [VW-1:0] link_o,
  output logic [VW-1:0] keep_o
);

  // the only three carry-link patterns that exist
  localparam logic [VW-1:0] LINK_X1 = VW'(link_mask(MODE_X1, VW, EW_WIDE, EW_NARROW));
  localparam logic [VW-1:0] LINK_X2 = VW'(link_mask(MODE_X2, VW, EW_WIDE, EW_NARROW));
  localparam logic [VW-1:0] LINK_X4 = VW'(link_mask(MODE_X4, VW, EW_WIDE, EW_NARROW));
  localparam logic [VW-1:0] KEEP_X1 = VW'(elem_mask(MODE_X1, VW, EW_WIDE, EW_NARROW));
  localparam logic [VW-1:0] KEEP_X2 = VW'(elem_mask(MODE_X2, VW, EW_WIDE, EW_NARROW));
  localparam logic [VW-1:0] KEEP_X4 = VW'(elem_mask(MODE_X4, VW, EW_WIDE, EW_NARROW));

  mode_e mode;
  assign mode = mode_e'(mode_i);

  always_comb begin
    case (mode)
      MODE_X2: begin
        link_o = LINK_X2;
        keep_o = KEEP_X2;
      end
      MODE_X4: begin
        link_o = LINK_X4;
        keep_o = KEEP_X4;
      end
      default: begin
        link_o = LINK_X1;
        keep_o = KEEP_X1;
      end
    endcase
  end

endmodule

// File: rtl/simd_pad_ripple.sv
module simd_pad_ripple #(
  parameter int            VW   = 32,
  parameter logic [VW-1:0] LIVE = '1
) (
  input  logic [VW-1:0] a_i,
  input  logic [VW-1:0] b_i,
  input  logic [VW-1:0] link_i,
  output logic [VW-1:0] sum_o,
  output logic [VW-1:0] cout_o
);

  for (genvar g = 0; g < VW; g++) begin : g_bit
    if (!LIVE[g]) begin : g_blank
      // never part of any element: no adder cell, constant zero
      assign sum_o[g]  = a_i[g] & b_i[g] & link_i[g] & 1'b0;
      assign cout_o[g] = 1'b0;
    end else begin : g_live
      logic cin;
      if (g == 0) begin : g_first
        assign cin = link_i[g] & 1'b0;
      end else begin : g_next
        assign cin = link_i[g] & cout_o[g-1];
      end
      assign sum_o[g]  = a_i[g] ^ b_i[g] ^ cin;
      assign cout_o[g] = (a_i[g] & b_i[g]) | ((a_i[g] ^ b_i[g]) & cin);
    end
  end

endmodule

// File: rtl/simd_pad_carry_tap.sv
module simd_pad_carry_tap
  import simd_pad_pkg::*;
#(
  parameter int VW        = 32,
  parameter int EW_WIDE   = 11,
  parameter int EW_NARROW = 5,
  parameter int NC        = 4
) (
  input  logic [1:0]    mode_i,
  input  logic [VW-1:0] cout_i,
  output logic [NC-1:0] carry_o
);

  mode_e mode;
  assign mode = mode_e'(mode_i);

  for (genvar i = 0; i < NC; i++) begin : g_elem
    localparam logic [VW-1:0] T_X1 = VW'(tap_mask(MODE_X1, i, VW, EW_WIDE, EW_NARROW));
    localparam logic [VW-1:0] T_X2 = VW'(tap_mask(MODE_X2, i, VW, EW_WIDE, EW_NARROW));
    localparam logic [VW-1:0] T_X4 = VW'(tap_mask(MODE_X4, i, VW, EW_WIDE, EW_NARROW));
    logic [VW-1:0] sel;
    always_comb begin
      case (mode)
        MODE_X2: sel = T_X2;
        MODE_X4: sel = T_X4;
        default: sel = T_X1;
      endcase
    end
    assign carry_o[i] = |(cout_i & sel);
  end

endmodule

// File: rtl/simd_pad_adder.sv
module simd_pad_adder
  import simd_pad_pkg::*;
#(
  parameter int VW        = 32,
  parameter int EW_WIDE   = 11,
  parameter int EW_NARROW = 5,
  parameter int NC        = 4
) (
  input  logic [1:0]    mode_i,
  input  logic [VW-1:0] a_i,
  input  logic [VW-1:0] b_i,
  output logic [VW-1:0] sum_o,
  output logic [NC-1:0] carry_o
);

  localparam logic [VW-1:0] LIVE = VW'(union_mask(VW, EW_WIDE, EW_NARROW));

  logic [VW-1:0] link;
  logic [VW-1:0] keep;
  logic [VW-1:0] raw_sum;
  logic [VW-1:0] cout;

  simd_pad_mode_dec #(
    .VW(VW), .EW_WIDE(EW_WIDE), .EW_NARROW(EW_NARROW)
  ) u_dec (
    .mode_i (mode_i),
    .link_o (link),
    .keep_o (keep)
  );

  simd_pad_ripple #(
    .VW(VW), .LIVE(LIVE)
  ) u_add (
    .a_i    (a_i),
    .b_i    (b_i),
    .link_i (link),
    .sum_o  (raw_sum),
    .cout_o (cout)
  );

  simd_pad_carry_tap #(
    .VW(VW), .EW_WIDE(EW_WIDE), .EW_NARROW(EW_NARROW), .NC(NC)
  ) u_tap (
    .mode_i  (mode_i),
    .cout_i  (cout),
    .carry_o (carry_o)
  );

  assign sum_o = raw_sum & keep;

  logic [EW_NARROW:0] low_ref;
  assign low_ref = {1'b0, a_i[EW_NARROW-1:0]} + {1'b0, b_i[EW_NARROW-1:0]};

  always_comb begin
    // R7
    blank_bits_zero_chk: assert ((sum_o & ~LIVE) == '0)
      else $error("blank bit driven");
    // R1
    lsb_no_carry_in_chk: assert (sum_o[0] == (a_i[0] ^ b_i[0]))
      else $error("carry entered bit 0");
    // R8
    if (mode_i == 2'd0 || mode_i == 2'd3) begin
      carry_hi_zero_chk: assert (carry_o[NC-1:1] == '0)
        else $error("carry on absent element");
    end
    // R5
    if (mode_i == 2'd1 || mode_i == 2'd2) begin
      lane_cut_chk: assert (link[VW/2] == 1'b0)
        else $error("carry linked across lane boundary");
    end
    // R3
    if (mode_i == 2'd2) begin
      narrow_carry_chk: assert (carry_o[0] == low_ref[EW_NARROW])
        else $error("narrow element carry wrong");
    end
  end

endmodule

// File: tb/simd_pad_adder_tb_top.sv
module simd_pad_adder_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [1:0]  mode;
  logic [31:0] a;
  logic [31:0] b;
  logic [31:0] sum;
  logic [3:0]  carry;

  int tests;
  int fails;
  bit done;

  simd_pad_adder dut_i (
    .mode_i  (mode),
    .a_i     (a),
    .b_i     (b),
    .sum_o   (sum),
    .carry_o (carry)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] emask(logic [1:0] m);
    case (m)
      2'd1:    return 32'h07FF07FF;
      2'd2:    return 32'h1F1F1F1F;
      default: return 32'h000007FF;
    endcase
  endfunction

  task automatic ref_add(input logic [1:0] m, input logic [31:0] x, input logic [31:0] y,
                         output logic [31:0] s, output logic [3:0] c);
    int n;
    int lw;
    int ew;
    n  = (m == 2'd1) ? 2 : (m == 2'd2) ? 4 : 1;
    ew = (m == 2'd2) ? 5 : 11;
    lw = 32 / n;
    s  = '0;
    c  = '0;
    for (int l = 0; l < n; l++) begin
      logic [31:0] ea;
      logic [31:0] eb;
      logic [31:0] es;
      ea = (x >> (l*lw)) & ((32'd1 << ew) - 1);
      eb = (y >> (l*lw)) & ((32'd1 << ew) - 1);
      es = ea + eb;
      s  = s | ((es & ((32'd1 << ew) - 1)) << (l*lw));
      c[l] = es[ew];
    end
  endtask

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply(input logic [1:0] m, input logic [31:0] x, input logic [31:0] y);
    @(negedge clk);
    mode = m;
    a    = x;
    b    = y;
    #(CLK_PERIOD/4);
  endtask

  task automatic t_reset_state();
    apply(2'd0, 32'h0, 32'h0);
    check("R1 reset sum", sum, 32'h0);
    check("R8 reset carry", {28'h0, carry}, 32'h0);
  endtask

  task automatic t_mode_random(input logic [1:0] m, input string req, input int n);
    logic [31:0] es;
    logic [3:0]  ec;
    for (int k = 0; k < n; k++) begin
      logic [31:0] x;
      logic [31:0] y;
      x = $urandom;
      y = $urandom;
      apply(m, x, y);
      ref_add(m, x, y, es, ec);
      check(req, sum, es);
      check("R8 carry", {28'h0, carry}, {28'h0, ec});
    end
  endtask

  task automatic t_reserved();
    logic [31:0] es;
    logic [3:0]  ec;
    for (int k = 0; k < 8; k++) begin
      logic [31:0] x;
      logic [31:0] y;
      x = $urandom;
      y = $urandom;
      apply(2'd3, x, y);
      ref_add(2'd0, x, y, es, ec);
      check("R4 sum", sum, es);
      check("R4 carry", {28'h0, carry}, {28'h0, ec});
    end
  endtask

  // every element saturates; carries must stay inside
  task automatic t_overflow();
    apply(2'd0, 32'hFFFFFFFF, 32'hFFFFFFFF);
    check("R5 x1 ones", sum, 32'h000007FE);
    check("R8 x1 ones carry", {28'h0, carry}, 32'h1);
    apply(2'd0, 32'h000007FF, 32'h00000001);
    check("R5 x1 wrap", sum, 32'h0);
    check("R1 x1 wrap carry", {28'h0, carry}, 32'h1);
    apply(2'd1, 32'hFFFFFFFF, 32'hFFFFFFFF);
    check("R5 x2 ones", sum, 32'h07FE07FE);
    check("R2 x2 ones carry", {28'h0, carry}, 32'h3);
    apply(2'd1, 32'h000007FF, 32'h00000001);
    check("R5 x2 low wrap", sum, 32'h0);
    check("R2 x2 low wrap carry", {28'h0, carry}, 32'h1);
    apply(2'd2, 32'hFFFFFFFF, 32'hFFFFFFFF);
    check("R5 x4 ones", sum, 32'h1E1E1E1E);
    check("R3 x4 ones carry", {28'h0, carry}, 32'hF);
    apply(2'd2, 32'h001F001F, 32'h00010001);
    check("R5 x4 wrap", sum, 32'h0);
    check("R3 x4 wrap carry", {28'h0, carry}, 32'h5);
    apply(2'd2, 32'h1F000000, 32'h01000000);
    check("R8 x4 top carry", {28'h0, carry}, 32'h8);
  endtask

  task automatic t_padding();
    for (int mi = 0; mi < 4; mi++) begin
      for (int k = 0; k < 4; k++) begin
        logic [31:0] x;
        logic [31:0] y;
        x = $urandom | 32'hE0E0E0E0;
        y = $urandom | 32'hE0E0E0E0;
        apply(2'(mi), x, y);
        check("R6 lane padding", sum & ~emask(2'(mi)), 32'h0);
        check("R7 blank bits", sum & 32'hE000E000, 32'h0);
      end
    end
  endtask

  initial begin
    tests = 0;
    fails = 0;
    done  = 1'b0;
    rst_n = 1'b0;
    mode  = 2'd0;
    a     = '0;
    b     = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    t_reset_state();
    t_mode_random(2'd0, "R1 sum", 20);
    t_mode_random(2'd1, "R2 sum", 20);
    t_mode_random(2'd2, "R3 sum", 20);
    t_reserved();
    t_overflow();
    t_padding();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired got hang expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule